// File: doc/BRIEF.md
# Overlay Colour-Key and Cursor Mixer

The mixer sits at the end of a display scanout path and builds each final pixel from three sources that arrive on the same clock: a primary RGB pixel tagged with its screen coordinates, the matching pixel of an overlay stream, and the matching pixel of a hardware cursor image. The overlay is confined to a programmable rectangular window. In position mode it covers the whole window. In key mode it appears only where the primary pixel matches a programmed key colour. The match can be masked bit by bit.

A 64x64 cursor is placed at a programmable screen position and drawn above both the primary and the overlay. In the two-colour mode each cursor pixel is a 2-bit code. In the ARGB mode it is an alpha-weighted colour blended over the pixel beneath. Blanking, horizontal sync and vertical sync travel through the same two register stages as the pixel, so they stay aligned with it. Fetching pixels from memory, scaling and colour-space conversion are done elsewhere.

Top module: `ovl_cursor_mixer`

## Requirements
- R1: The output lags the input by exactly two clock cycles. `out_de`, `out_hs` and `out_vs` are the inputs `in_de`, `in_hs` and `in_vs` from two cycles earlier. All outputs are 0 after reset.
- R2: In position mode (`ovl_key_mode`=0) with the overlay enabled, the overlay pixel replaces the primary pixel whenever `win_x0 <= x < win_x1` and `win_y0 <= y < win_y1`. Outside that window the primary pixel is used.
- R3: In key mode (`ovl_key_mode`=1), the overlay replaces the primary pixel only inside the window and only where the primary pixel equals `key_rgb` on every unmasked bit.
- R4: A 0 bit in `key_mask` removes that bit from the key compare. An all-zero byte therefore removes that channel. Pixels are packed as R in [23:16], G in [15:8] and B in [7:0].
- R5: With `ovl_en`=0 the overlay never appears.
- R6: The cursor covers `cur_x <= x < cur_x+64` and `cur_y <= y < cur_y+64`. Outside that box, or with `cur_en`=0, the pixel beneath passes through unchanged.
- R7: In two-colour mode (`cur_argb`=0), `cur_px[1:0]` selects the output. 00 is transparent and keeps the pixel beneath. 01 gives `cur_col0`. 10 gives `cur_col1`. 11 gives the bitwise inverse of the pixel beneath.
- R8: In ARGB mode the alpha is taken from `cur_px[31:24]` and the colour from `cur_px[23:0]`. Each channel equals (alpha*cursor + (255-alpha)*beneath)/255, rounded to the nearest integer. Alpha 0 gives the pixel beneath exactly. Alpha 255 gives the cursor colour exactly.
- R9: `out_rgb` is 0 whenever `out_de` is 0.
- R10: The cursor is drawn over the overlay. The pixel beneath the cursor is the result of the overlay selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_de | input | 1 | Active-video flag of the incoming pixel |
| in_hs | input | 1 | Horizontal sync of the incoming pixel |
| in_vs | input | 1 | Vertical sync of the incoming pixel |
| in_x | input | XW | Column of the incoming pixel |
| in_y | input | YW | Row of the incoming pixel |
| in_rgb | input | 24 | Primary pixel |
| ovl_rgb | input | 24 | Overlay pixel for the same position |
| cur_px | input | 32 | Cursor image pixel for the same position |
| ovl_en | input | 1 | Overlay enable |
| ovl_key_mode | input | 1 | 1 = key mode, 0 = position mode |
| win_x0 | input | XW | First column of the overlay window |
| win_x1 | input | XW | Column just past the overlay window |
| win_y0 | input | YW | First row of the overlay window |
| win_y1 | input | YW | Row just past the overlay window |
| key_rgb | input | 24 | Key colour |
| key_mask | input | 24 | Per-bit compare enable for the key |
| cur_en | input | 1 | Cursor enable |
| cur_argb | input | 1 | 1 = ARGB cursor, 0 = two-colour cursor |
| cur_x | input | XW | Cursor left column |
| cur_y | input | YW | Cursor top row |
| cur_col0 | input | 24 | Two-colour cursor colour for code 01 |
| cur_col1 | input | 24 | Two-colour cursor colour for code 10 |
| out_de | output | 1 | Delayed active-video flag |
| out_hs | output | 1 | Delayed horizontal sync |
| out_vs | output | 1 | Delayed vertical sync |
| out_rgb | output | 24 | Final pixel |

## Verification
The block keeps no state beyond its two pipeline stages, so any corrupted internal value appears at the ports within two cycles. A wrong overlay or cursor decision in the first stage shows up one cycle later as a pixel that is primary where overlay was expected, or unblended where the cursor should be. A misaligned stage shows up as a sync or data-enable edge that no longer lines up with its pixel. The blend is checked at the alpha extremes and at intermediate alphas whose exact rounded quotients are known, because a divide approximation goes wrong first at those points.

// File: rtl/mix_pkg.sv
package mix_pkg;
    localparam int unsigned CHAN_W = 8;
    localparam int unsigned NCHAN  = 3;
    localparam int unsigned RGB_W  = CHAN_W * NCHAN;

    typedef logic [CHAN_W-1:0] chan_t;
    typedef logic [RGB_W-1:0]  rgb_t;

    typedef enum logic [1:0] {
        MONO_CLEAR  = 2'b00,
        MONO_COL0   = 2'b01,
        MONO_COL1   = 2'b10,
        MONO_INVERT = 2'b11
    } mono_code_e;
endpackage

// File: rtl/mix_ovl_select.sv
module mix_ovl_select
    import mix_pkg::*;
#(
    parameter int unsigned XW = 12,
    parameter int unsigned YW = 12
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  rgb_t          prim_rgb,
    input  rgb_t          ovl_rgb,
    input  logic          ovl_en,
    input  logic          key_mode,
    input  logic [XW-1:0] win_x0,
    input  logic [XW-1:0] win_x1,
    input  logic [YW-1:0] win_y0,
    input  logic [YW-1:0] win_y1,
    input  rgb_t          key_rgb,
    input  rgb_t          key_mask,
    output rgb_t          under_rgb
);
    logic in_win;
    logic key_hit;
    logic take_ovl;
    logic [NCHAN-1:0] chan_eq;

    // per-channel masked compare; an all-zero channel mask makes it match
    for (genvar c = 0; c < NCHAN; c++) begin : g_cmp
        assign chan_eq[c] = (((prim_rgb[c*CHAN_W +: CHAN_W] ^ key_rgb[c*CHAN_W +: CHAN_W])
                              & key_mask[c*CHAN_W +: CHAN_W]) == '0);
    end

    always_comb begin
        in_win    = (x >= win_x0) && (x < win_x1) && (y >= win_y0) && (y < win_y1);
        key_hit   = &chan_eq;
        take_ovl  = ovl_en && in_win && (!key_mode || key_hit);
        under_rgb = take_ovl ? ovl_rgb : prim_rgb;
    end
endmodule

// File: rtl/mix_cursor_hit.sv
module mix_cursor_hit #(
    parameter int unsigned XW      = 12,
    parameter int unsigned YW      = 12,
    parameter int unsigned CUR_DIM = 64
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic [XW-1:0] cur_x,
    input  logic [YW-1:0] cur_y,
    input  logic          cur_en,
    output logic          hit
);
    localparam int unsigned DIM_XW = XW + 1;
    localparam int unsigned DIM_YW = YW + 1;
    localparam logic [DIM_XW-1:0] DIM_X = DIM_XW'(CUR_DIM);
    localparam logic [DIM_YW-1:0] DIM_Y = DIM_YW'(CUR_DIM);

    logic [DIM_XW-1:0] dx;
    logic [DIM_YW-1:0] dy;
    logic in_x, in_y;

    always_comb begin
        // one extra bit holds the borrow: a set top bit means left of / above the box
        dx   = {1'b0, x} - {1'b0, cur_x};
        dy   = {1'b0, y} - {1'b0, cur_y};
        in_x = !dx[DIM_XW-1] && (dx < DIM_X);
        in_y = !dy[DIM_YW-1] && (dy < DIM_Y);
        hit  = cur_en && in_x && in_y;
    end
endmodule

// File: rtl/mix_alpha_blend.sv
module mix_alpha_blend
    import mix_pkg::*;
(
    input  chan_t alpha,
    input  rgb_t  top_rgb,
    input  rgb_t  bot_rgb,
    output rgb_t  mix_rgb
);
    localparam int unsigned PW = 2 * CHAN_W;
    localparam logic [CHAN_W-1:0] FULL = '1;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic [PW-1:0] sum;
        logic [PW:0]   biased;
        logic [PW:0]   quot;

        always_comb begin
            sum    = PW'(alpha) * PW'(top_rgb[c*CHAN_W +: CHAN_W])
                   + PW'(FULL - alpha) * PW'(bot_rgb[c*CHAN_W +: CHAN_W]);
            // divide by 255 with rounding: (t + t>>8) >> 8, t = sum + 128
            biased = (PW+1)'(sum) + (PW+1)'(1 << (CHAN_W-1));
            quot   = (biased + (biased >> CHAN_W)) >> CHAN_W;
            mix_rgb[c*CHAN_W +: CHAN_W] = quot[CHAN_W-1:0];
        end
    end
endmodule

// File: rtl/ovl_cursor_mixer.sv
module ovl_cursor_mixer
    import mix_pkg::*;
#(
    parameter int unsigned XW      = 12,
    parameter int unsigned YW      = 12,
    parameter int unsigned CUR_DIM = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_de,
    input  logic              in_hs,
    input  logic              in_vs,
    input  logic [XW-1:0]     in_x,
    input  logic [YW-1:0]     in_y,
    input  logic [23:0]       in_rgb,
    input  logic [23:0]       ovl_rgb,
    input  logic [31:0]       cur_px,
    input  logic              ovl_en,
    input  logic              ovl_key_mode,
    input  logic [XW-1:0]     win_x0,
    input  logic [XW-1:0]     win_x1,
    input  logic [YW-1:0]     win_y0,
    input  logic [YW-1:0]     win_y1,
    input  logic [23:0]       key_rgb,
    input  logic [23:0]       key_mask,
    input  logic              cur_en,
    input  logic              cur_argb,
    input  logic [XW-1:0]     cur_x,
    input  logic [YW-1:0]     cur_y,
    input  logic [23:0]       cur_col0,
    input  logic [23:0]       cur_col1,
    output logic              out_de,
    output logic              out_hs,
    output logic              out_vs,
    output logic [23:0]       out_rgb
);
    typedef struct packed {
        logic       de;
        logic       hs;
        logic       vs;
        logic       hit;
        logic       argb;
        logic [1:0] code;
        chan_t      alpha;
        rgb_t       cur_rgb;
        rgb_t       under;
    } stage1_t;

    typedef struct packed {
        logic de;
        logic hs;
        logic vs;
        rgb_t rgb;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t state_d, state_q;

    rgb_t under_w;
    logic hit_w;
    rgb_t blend_w;

    mix_ovl_select #(.XW(XW), .YW(YW)) ovl_sel_i (
        .x         (in_x),
        .y         (in_y),
        .prim_rgb  (in_rgb),
        .ovl_rgb   (ovl_rgb),
        .ovl_en    (ovl_en),
        .key_mode  (ovl_key_mode),
        .win_x0    (win_x0),
        .win_x1    (win_x1),
        .win_y0    (win_y0),
        .win_y1    (win_y1),
        .key_rgb   (key_rgb),
        .key_mask  (key_mask),
        .under_rgb (under_w)
    );

    mix_cursor_hit #(.XW(XW), .YW(YW), .CUR_DIM(CUR_DIM)) cur_hit_i (
        .x      (in_x),
        .y      (in_y),
        .cur_x  (cur_x),
        .cur_y  (cur_y),
        .cur_en (cur_en),
        .hit    (hit_w)
    );

    mix_alpha_blend blend_i (
        .alpha   (state_q.s1.alpha),
        .top_rgb (state_q.s1.cur_rgb),
        .bot_rgb (state_q.s1.under),
        .mix_rgb (blend_w)
    );

    always_comb begin
        state_d = state_q;

        // stage 1: overlay selection, cursor hit test, capture of cursor pixel
        state_d.s1.de      = in_de;
        state_d.s1.hs      = in_hs;
        state_d.s1.vs      = in_vs;
        state_d.s1.hit     = hit_w;
        state_d.s1.argb    = cur_argb;
        state_d.s1.code    = cur_px[1:0];
        state_d.s1.alpha   = cur_px[31:24];
        state_d.s1.cur_rgb = cur_px[23:0];
        state_d.s1.under   = under_w;

        // stage 2: cursor composition over the selected pixel
        state_d.s2.de = state_q.s1.de;
        state_d.s2.hs = state_q.s1.hs;
        state_d.s2.vs = state_q.s1.vs;
        if (!state_q.s1.de) begin
            state_d.s2.rgb = '0;
        end else if (!state_q.s1.hit) begin
            state_d.s2.rgb = state_q.s1.under;
        end else if (state_q.s1.argb) begin
            state_d.s2.rgb = blend_w;
        end else begin
            unique case (mono_code_e'(state_q.s1.code))
                MONO_CLEAR:  state_d.s2.rgb = state_q.s1.under;
                MONO_COL0:   state_d.s2.rgb = cur_col0;
                MONO_COL1:   state_d.s2.rgb = cur_col1;
                MONO_INVERT: state_d.s2.rgb = ~state_q.s1.under;
                default:     state_d.s2.rgb = state_q.s1.under;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_de  = state_q.s2.de;
    assign out_hs  = state_q.s2.hs;
    assign out_vs  = state_q.s2.vs;
    assign out_rgb = state_q.s2.rgb;

    // cycles since reset, saturating at 2, so $past(…,2) only sees post-reset inputs
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)            warm_q <= '0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    p_sync_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> ({out_de, out_hs, out_vs} == {$past(in_de, 2), $past(in_hs, 2), $past(in_vs, 2)}));

    p_blank_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_de |-> (out_rgb == '0));

    p_outside_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.s1.de && !state_q.s1.hit) |=> (out_rgb == $past(state_q.s1.under)));

    p_mono_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.s1.de && state_q.s1.hit && !state_q.s1.argb && state_q.s1.code == 2'b00)
        |=> (out_rgb == $past(state_q.s1.under)));

    p_alpha_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.s1.de && state_q.s1.hit && state_q.s1.argb && state_q.s1.alpha == 8'd0)
        |=> (out_rgb == $past(state_q.s1.under)));

    p_alpha_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.s1.de && state_q.s1.hit && state_q.s1.argb && state_q.s1.alpha == 8'hFF)
        |=> (out_rgb == $past(state_q.s1.cur_rgb)));
endmodule

// File: tb/ovl_cursor_mixer_tb_top.sv
module ovl_cursor_mixer_tb_top;
    localparam int XW = 12;
    localparam int YW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_de = 0, in_hs = 0, in_vs = 0;
    logic [XW-1:0] in_x = '0;
    logic [YW-1:0] in_y = '0;
    logic [23:0] in_rgb = '0, ovl_rgb = '0;
    logic [31:0] cur_px = '0;
    logic ovl_en = 0, ovl_key_mode = 0;
    logic [XW-1:0] win_x0 = '0, win_x1 = '0;
    logic [YW-1:0] win_y0 = '0, win_y1 = '0;
    logic [23:0] key_rgb = '0, key_mask = '0;
    logic cur_en = 0, cur_argb = 0;
    logic [XW-1:0] cur_x = '0;
    logic [YW-1:0] cur_y = '0;
    logic [23:0] cur_col0 = '0, cur_col1 = '0;
    logic out_de, out_hs, out_vs;
    logic [23:0] out_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ovl_cursor_mixer #(.XW(XW), .YW(YW), .CUR_DIM(64)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
        .in_x(in_x), .in_y(in_y), .in_rgb(in_rgb), .ovl_rgb(ovl_rgb), .cur_px(cur_px),
        .ovl_en(ovl_en), .ovl_key_mode(ovl_key_mode),
        .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
        .key_rgb(key_rgb), .key_mask(key_mask),
        .cur_en(cur_en), .cur_argb(cur_argb), .cur_x(cur_x), .cur_y(cur_y),
        .cur_col0(cur_col0), .cur_col1(cur_col1),
        .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs), .out_rgb(out_rgb)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // apply one pixel, hold it, sample after the two pipeline edges
    task automatic pix(input int x, input int y, input logic [23:0] p,
                       input logic [23:0] o, input logic [31:0] c);
        @(negedge clk);
        in_de = 1; in_x = XW'(x); in_y = YW'(y);
        in_rgb = p; ovl_rgb = o; cur_px = c;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] ref_mix(input int a, input int t, input int b);
        int s;
        s = a * t + (255 - a) * b;
        return 8'((2 * s + 255) / 510);
    endfunction

    task automatic t_reset;
        @(negedge clk);
        chk("R1 reset de/hs/vs", {29'd0, out_de, out_hs, out_vs}, 32'd0);
        chk("R1 reset rgb", {8'd0, out_rgb}, 32'd0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        in_de = 1; in_hs = 1; in_vs = 0; in_rgb = 24'h123456;
        @(negedge clk);
        in_de = 0; in_hs = 0; in_vs = 1;
        chk("R1 one edge no output", {29'd0, out_de, out_hs, out_vs}, 32'd0);
        @(negedge clk);
        in_vs = 0;
        chk("R1 two edges de/hs/vs", {29'd0, out_de, out_hs, out_vs}, {29'd0, 3'b110});
        chk("R1 two edges rgb", {8'd0, out_rgb}, 32'h123456);
        @(negedge clk);
        chk("R1 trailing sync", {29'd0, out_de, out_hs, out_vs}, {29'd0, 3'b001});
        chk("R9 blank rgb zero", {8'd0, out_rgb}, 32'd0);
    endtask

    task automatic t_position;
        ovl_en = 1; ovl_key_mode = 0;
        win_x0 = 20; win_x1 = 30; win_y0 = 5; win_y1 = 8;
        pix(20, 5, 24'h111111, 24'hAAAAAA, 0);
        chk("R2 window corner", {8'd0, out_rgb}, 32'hAAAAAA);
        pix(29, 7, 24'h111111, 24'hAAAAAA, 0);
        chk("R2 last inside", {8'd0, out_rgb}, 32'hAAAAAA);
        pix(30, 5, 24'h111111, 24'hAAAAAA, 0);
        chk("R2 right edge excl", {8'd0, out_rgb}, 32'h111111);
        pix(25, 8, 24'h111111, 24'hAAAAAA, 0);
        chk("R2 bottom edge excl", {8'd0, out_rgb}, 32'h111111);
        pix(19, 6, 24'h111111, 24'hAAAAAA, 0);
        chk("R2 left outside", {8'd0, out_rgb}, 32'h111111);
    endtask

    task automatic t_disabled;
        ovl_en = 0;
        pix(25, 6, 24'h222222, 24'hBBBBBB, 0);
        chk("R5 overlay off", {8'd0, out_rgb}, 32'h222222);
    endtask

    task automatic t_key;
        ovl_en = 1; ovl_key_mode = 1;
        win_x0 = 0; win_x1 = 100; win_y0 = 0; win_y1 = 100;
        key_rgb = 24'h00FF00; key_mask = 24'hFFFFFF;
        pix(10, 10, 24'h00FF00, 24'hC0C0C0, 0);
        chk("R3 key match", {8'd0, out_rgb}, 32'hC0C0C0);
        pix(10, 10, 24'h00FE00, 24'hC0C0C0, 0);
        chk("R3 key mismatch", {8'd0, out_rgb}, 32'h00FE00);
        pix(200, 10, 24'h00FF00, 24'hC0C0C0, 0);
        chk("R3 key outside window", {8'd0, out_rgb}, 32'h00FF00);
    endtask

    task automatic t_mask;
        key_mask = 24'hFFFF00;
        pix(11, 11, 24'h00FF37, 24'hD0D0D0, 0);
        chk("R4 blue masked", {8'd0, out_rgb}, 32'hD0D0D0);
        key_mask = 24'hFFFFFE;
        pix(11, 11, 24'h00FF01, 24'hD0D0D0, 0);
        chk("R4 lsb masked", {8'd0, out_rgb}, 32'hD0D0D0);
        pix(11, 11, 24'h00FF02, 24'hD0D0D0, 0);
        chk("R4 bit1 compared", {8'd0, out_rgb}, 32'h00FF02);
        ovl_en = 0;
    endtask

    task automatic t_cursor_box;
        cur_en = 1; cur_argb = 0; cur_x = 100; cur_y = 50;
        cur_col0 = 24'hF00F00; cur_col1 = 24'h0F00F0;
        pix(100, 50, 24'h333333, 0, 32'h1);
        chk("R6 box top-left", {8'd0, out_rgb}, 32'hF00F00);
        pix(163, 113, 24'h333333, 0, 32'h1);
        chk("R6 box bottom-right", {8'd0, out_rgb}, 32'hF00F00);
        pix(164, 50, 24'h333333, 0, 32'h1);
        chk("R6 right of box", {8'd0, out_rgb}, 32'h333333);
        pix(100, 114, 24'h333333, 0, 32'h1);
        chk("R6 below box", {8'd0, out_rgb}, 32'h333333);
        pix(99, 60, 24'h333333, 0, 32'h1);
        chk("R6 left of box", {8'd0, out_rgb}, 32'h333333);
        cur_en = 0;
        pix(110, 60, 24'h333333, 0, 32'h1);
        chk("R6 cursor disabled", {8'd0, out_rgb}, 32'h333333);
        cur_en = 1;
    endtask

    task automatic t_mono;
        pix(110, 60, 24'h3C5A96, 0, 32'h0);
        chk("R7 code 00 clear", {8'd0, out_rgb}, 32'h3C5A96);
        pix(110, 60, 24'h3C5A96, 0, 32'h2);
        chk("R7 code 10 col1", {8'd0, out_rgb}, 32'h0F00F0);
        pix(110, 60, 24'h3C5A96, 0, 32'h3);
        chk("R7 code 11 invert", {8'd0, out_rgb}, 32'hC3A569);
    endtask

    task automatic t_argb;
        cur_argb = 1;
        pix(110, 60, 24'h123456, 0, 32'h00FFFFFF);
        chk("R8 alpha 0", {8'd0, out_rgb}, 32'h123456);
        pix(110, 60, 24'h123456, 0, 32'hFFABCDEF);
        chk("R8 alpha 255", {8'd0, out_rgb}, 32'hABCDEF);
        pix(110, 60, 24'h000000, 0, 32'h80FF00FF);
        chk("R8 alpha 128", {8'd0, out_rgb}, 32'h800080);
        pix(110, 60, 24'h000000, 0, 32'h01FFFFFF);
        chk("R8 alpha 1", {8'd0, out_rgb}, 32'h010101);
        pix(110, 60, 24'h321E0A, 0, 32'h64C8FA14);
        chk("R8 alpha 100", {8'd0, out_rgb},
            {8'd0, ref_mix(100, 200, 50), ref_mix(100, 250, 30), ref_mix(100, 20, 10)});
        chk("R8 alpha 100 red literal", {24'd0, out_rgb[23:16]}, 32'd109);
        cur_argb = 0;
    endtask

    task automatic t_priority;
        ovl_en = 1; ovl_key_mode = 0;
        win_x0 = 100; win_x1 = 120; win_y0 = 50; win_y1 = 70;
        pix(110, 60, 24'h444444, 24'h0F0F0F, 32'h3);
        chk("R10 cursor over overlay", {8'd0, out_rgb}, 32'hF0F0F0);
        ovl_en = 0;
    endtask

    task automatic t_blank;
        @(negedge clk);
        in_de = 0; in_x = 110; in_y = 60; in_rgb = 24'h777777; cur_px = 32'h1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 blank de", {31'd0, out_de}, 32'd0);
        chk("R9 blank rgb under cursor", {8'd0, out_rgb}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1;
        t_latency();
        t_position();
        t_disabled();
        t_key();
        t_mask();
        t_cursor_box();
        t_mono();
        t_argb();
        t_priority();
        t_blank();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule